// File: doc/BRIEF.md
# Dual Converter Start Sequencer

This block sequences conversions for two successive-approximation converter channels, A and B, from a small register interface. Each channel picks its start trigger with a mode field: a software write, one of two timer overflow pulses, or a rising edge on its own external start pin. Channel B has one more choice, which lets a software start of channel A also start B. The conversion clock is a tick derived from the system clock by a programmable divider. An optional tracking window can be placed in front of each conversion.

Every channel shows a busy flag for the length of its conversion. When busy falls, a sticky completion flag is set, and the flag drives an interrupt line when its enable is set. The analog core is modelled as an abstract converter. It captures its input word when conversion begins and returns that word after a fixed number of conversion ticks. In differential mode channel B runs in lockstep with channel A, and A's result register receives the sum of both results.

Top module: `dual_conv_sequencer`

## Requirements
- R1: After reset every register reads 0, both busy outputs are 0 and both interrupt lines are 0. Register map: address 0 is control A, address 1 is control B, address 2 holds the divide field in bits [7:0], address 3 is result A, address 4 is result B.
- R2: Writing a control word with bit 0 set starts a software-mode channel (mode 0). With divide field 0 and no tracking, busy is high for exactly 16 system clocks. The result register then holds the input word that was present when conversion began.
- R3: The conversion tick occurs once every (D+1) system clocks for divide field D. A conversion of N ticks therefore keeps busy high for between N(D+1)-D and N(D+1) system clocks.
- R4: When the track bit (bit 2 of a control word) is set, a start first runs 18 ticks of tracking and then 16 ticks of conversion, so N = 34.
- R5: Mode field value 1 starts on a pulse of tmr2_ovf and value 2 on a pulse of tmr3_ovf. A pulse on the other timer input starts nothing.
- R6: In mode 3 the channel's external pin passes through a two-stage synchronizer and starts on a rising edge. Busy is still low after the second rising clock edge after the pin rises and is high after the third. The track bit is ignored in this mode.
- R7: Channel B mode 4 starts B whenever control A is written with bit 0 set.
- R8: A start request that arrives while a channel is busy is ignored. It neither lengthens the current conversion nor queues a second one.
- R9: Completion sets the channel's flag (bit 1 of its control word). The flag stays set until a control write with bit 1 equal to 0, and a write with bit 1 equal to 1 leaves it unchanged. The interrupt line equals the flag gated by the enable bit (bit 3).
- R10: With the differential bit (control A bit 6) set, B starts together with A and uses A's track setting, and B's own start source is ignored. Result A becomes (A + B) mod 2^16, and result B holds B's word.
- R11: Control A holds its mode in bits [5:4]. Control B holds its mode in bits [6:4]. Bit 0 reads back as the channel's busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| tmr2_ovf | input | 1 | First timer overflow pulse |
| tmr3_ovf | input | 1 | Second timer overflow pulse |
| ext_start_a | input | 1 | Asynchronous external start pin, channel A |
| ext_start_b | input | 1 | Asynchronous external start pin, channel B |
| ain_a | input | 16 | Abstract converter input word, channel A |
| ain_b | input | 16 | Abstract converter input word, channel B |
| busy_a | output | 1 | Channel A conversion in progress |
| busy_b | output | 1 | Channel B conversion in progress |
| irq_a | output | 1 | Channel A completion interrupt |
| irq_b | output | 1 | Channel B completion interrupt |

## Verification
The bench builds the block with its default parameters: 16-bit data, an 8-bit divide field, 16 conversion ticks, 18 tracking ticks and a two-stage synchronizer. At run time it walks divide values 0 to 3. With divide 0 the tick fires on every clock, so busy lengths and pin-to-busy latency can be checked exactly. With divides 1 to 3 the tick phase relative to the start moves, and the bench checks the busy length against the bounded window of R3. The short tracking and conversion counts keep every start mode, the lockstep differential sum with its 16-bit wrap, and the ignored-start cases within a few thousand cycles.

// File: rtl/convseq_pkg.sv
package convseq_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_TRACK = 2'd1,
        CH_CONV  = 2'd2
    } ch_state_e;

    localparam int REG_CTRL_A = 0;
    localparam int REG_CTRL_B = 1;
    localparam int REG_DIV    = 2;
    localparam int REG_RES_A  = 3;
    localparam int REG_RES_B  = 4;

    localparam int BIT_GO     = 0;
    localparam int BIT_FLAG   = 1;
    localparam int BIT_TRACK  = 2;
    localparam int BIT_IE     = 3;
    localparam int BIT_MODE   = 4;
    localparam int BIT_DIFF   = 6;

    localparam int SRC_SW     = 0;
    localparam int SRC_TMR2   = 1;
    localparam int SRC_TMR3   = 2;
    localparam int SRC_PIN    = 3;
    localparam int SRC_A_SW   = 4;

endpackage

// File: rtl/convseq_edge_sync.sv
module convseq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], pin};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.sh[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/convseq_clkdiv.sv
module convseq_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q >= div);

    always_comb begin
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/convseq_channel.sv
module convseq_channel
    import convseq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CONV_CLKS  = 16,
    parameter int TRACK_CLKS = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              track_en,
    input  logic [DATA_W-1:0] sample,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    localparam int MAX_CLKS = (CONV_CLKS > TRACK_CLKS) ? CONV_CLKS : TRACK_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);
    localparam logic [CNT_W-1:0] LAST_CONV  = CNT_W'(CONV_CLKS - 1);
    localparam logic [CNT_W-1:0] LAST_TRACK = CNT_W'(TRACK_CLKS - 1);

    typedef struct packed {
        ch_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] hold;
    } chan_t;

    chan_t c_d, c_q;

    always_comb begin
        c_d  = c_q;
        done = 1'b0;
        unique case (c_q.st)
            CH_IDLE: begin
                if (start) begin
                    c_d.cnt = '0;
                    if (track_en) begin
                        c_d.st = CH_TRACK;
                    end else begin
                        c_d.st   = CH_CONV;
                        c_d.hold = sample;
                    end
                end
            end
            CH_TRACK: begin
                if (tick) begin
                    if (c_q.cnt == LAST_TRACK) begin
                        c_d.st   = CH_CONV;
                        c_d.cnt  = '0;
                        c_d.hold = sample;
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
            end
            CH_CONV: begin
                if (tick) begin
                    if (c_q.cnt == LAST_CONV) begin
                        c_d.st  = CH_IDLE;
                        c_d.cnt = '0;
                        done    = 1'b1;
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
            end
            default: c_d.st = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: CH_IDLE, cnt: '0, hold: '0};
        else        c_q <= c_d;
    end

    assign busy   = (c_q.st != CH_IDLE);
    assign result = c_q.hold;
endmodule

// File: rtl/dual_conv_sequencer.sv
module dual_conv_sequencer
    import convseq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 3,
    parameter int DIV_W       = 8,
    parameter int CONV_CLKS   = 16,
    parameter int TRACK_CLKS  = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tmr2_ovf,
    input  logic              tmr3_ovf,
    input  logic              ext_start_a,
    input  logic              ext_start_b,
    input  logic [DATA_W-1:0] ain_a,
    input  logic [DATA_W-1:0] ain_b,
    output logic              busy_a,
    output logic              busy_b,
    output logic              irq_a,
    output logic              irq_b
);
    localparam int NCH = 2;

    typedef struct packed {
        logic [1:0]        a_mode;
        logic              a_track;
        logic              a_ie;
        logic              a_diff;
        logic              a_flag;
        logic [2:0]        b_mode;
        logic              b_track;
        logic              b_ie;
        logic              b_flag;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] res_a;
        logic [DATA_W-1:0] res_b;
    } regs_t;

    regs_t r_d, r_q;

    logic              conv_tick;
    logic [NCH-1:0]    pins, pin_rise;
    logic [NCH-1:0]    start_v, track_v, busy_v, done_v;
    logic [DATA_W-1:0] sample_v [NCH];
    logic [DATA_W-1:0] raw_v    [NCH];
    logic              wr_ctrl_a, wr_ctrl_b, wr_div;
    logic              go_a, go_b;
    logic              trig_a, trig_b, own_b;
    logic              flag_a_w, diff_w;
    logic [DATA_W-1:0] res_a_w;
    logic              unused_bits;

    assign pins = {ext_start_b, ext_start_a};
    assign sample_v[0] = ain_a;
    assign sample_v[1] = ain_b;

    convseq_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (r_q.div),
        .tick (conv_tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        convseq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[g]),
            .rise (pin_rise[g])
        );
        convseq_channel #(
            .DATA_W    (DATA_W),
            .CONV_CLKS (CONV_CLKS),
            .TRACK_CLKS(TRACK_CLKS)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (conv_tick),
            .start   (start_v[g]),
            .track_en(track_v[g]),
            .sample  (sample_v[g]),
            .busy    (busy_v[g]),
            .done    (done_v[g]),
            .result  (raw_v[g])
        );
    end

    // Register decode
    assign wr_ctrl_a = wr_en && (wr_addr == ADDR_W'(REG_CTRL_A));
    assign wr_ctrl_b = wr_en && (wr_addr == ADDR_W'(REG_CTRL_B));
    assign wr_div    = wr_en && (wr_addr == ADDR_W'(REG_DIV));
    assign go_a      = wr_ctrl_a && wr_data[BIT_GO];
    assign go_b      = wr_ctrl_b && wr_data[BIT_GO];

    // Start source selection, using the configuration in force before this write
    always_comb begin
        case (r_q.a_mode)
            2'(SRC_SW):   trig_a = go_a;
            2'(SRC_TMR2): trig_a = tmr2_ovf;
            2'(SRC_TMR3): trig_a = tmr3_ovf;
            default:      trig_a = pin_rise[0];
        endcase
        case (r_q.b_mode)
            3'(SRC_SW):   own_b = go_b;
            3'(SRC_TMR2): own_b = tmr2_ovf;
            3'(SRC_TMR3): own_b = tmr3_ovf;
            3'(SRC_PIN):  own_b = pin_rise[1];
            3'(SRC_A_SW): own_b = go_a;
            default:      own_b = 1'b0;
        endcase
        trig_b = r_q.a_diff ? trig_a : own_b;
    end

    assign start_v[0] = trig_a;
    assign start_v[1] = trig_b;
    assign track_v[0] = r_q.a_track && (r_q.a_mode != 2'(SRC_PIN));
    assign track_v[1] = r_q.a_diff ? track_v[0]
                                   : (r_q.b_track && (r_q.b_mode != 3'(SRC_PIN)));

    // Next-state for the register file
    always_comb begin
        r_d = r_q;
        if (wr_ctrl_a) begin
            r_d.a_mode  = wr_data[BIT_MODE +: 2];
            r_d.a_track = wr_data[BIT_TRACK];
            r_d.a_ie    = wr_data[BIT_IE];
            r_d.a_diff  = wr_data[BIT_DIFF];
            if (!wr_data[BIT_FLAG]) r_d.a_flag = 1'b0;
        end
        if (wr_ctrl_b) begin
            r_d.b_mode  = wr_data[BIT_MODE +: 3];
            r_d.b_track = wr_data[BIT_TRACK];
            r_d.b_ie    = wr_data[BIT_IE];
            if (!wr_data[BIT_FLAG]) r_d.b_flag = 1'b0;
        end
        if (wr_div) r_d.div = wr_data[DIV_W-1:0];
        if (done_v[0]) begin
            r_d.a_flag = 1'b1;
            r_d.res_a  = r_q.a_diff ? (raw_v[0] + raw_v[1]) : raw_v[0];
        end
        if (done_v[1]) begin
            r_d.b_flag = 1'b1;
            r_d.res_b  = raw_v[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(REG_CTRL_A): begin
                rd_data[BIT_GO]       = busy_v[0];
                rd_data[BIT_FLAG]     = r_q.a_flag;
                rd_data[BIT_TRACK]    = r_q.a_track;
                rd_data[BIT_IE]       = r_q.a_ie;
                rd_data[BIT_MODE +: 2] = r_q.a_mode;
                rd_data[BIT_DIFF]     = r_q.a_diff;
            end
            ADDR_W'(REG_CTRL_B): begin
                rd_data[BIT_GO]       = busy_v[1];
                rd_data[BIT_FLAG]     = r_q.b_flag;
                rd_data[BIT_TRACK]    = r_q.b_track;
                rd_data[BIT_IE]       = r_q.b_ie;
                rd_data[BIT_MODE +: 3] = r_q.b_mode;
            end
            ADDR_W'(REG_DIV):   rd_data[DIV_W-1:0] = r_q.div;
            ADDR_W'(REG_RES_A): rd_data = r_q.res_a;
            ADDR_W'(REG_RES_B): rd_data = r_q.res_b;
            default:            rd_data = '0;
        endcase
    end

    assign busy_a = busy_v[0];
    assign busy_b = busy_v[1];
    assign irq_a  = r_q.a_flag & r_q.a_ie;
    assign irq_b  = r_q.b_flag & r_q.b_ie;

    assign flag_a_w = r_q.a_flag;
    assign diff_w   = r_q.a_diff;
    assign res_a_w  = r_q.res_a;

    assign unused_bits = ^{wr_data[DATA_W-1:DIV_W], wr_data[BIT_DIFF+1]};
endmodule

// File: rtl/convseq_checker.sv
module convseq_checker #(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 3,
    parameter int CONV_CLKS  = 16,
    parameter int TRACK_CLKS = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_a,
    input logic              busy_b,
    input logic              flag_a,
    input logic              diff,
    input logic              tick,
    input logic [DATA_W-1:0] result_a,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_flag_bit
);
    localparam int LIMIT = CONV_CLKS + TRACK_CLKS;
    localparam int CW    = $clog2(LIMIT + 2) + 1;

    logic [CW-1:0] tick_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tick_cnt <= '0;
        else if (!busy_a) tick_cnt <= '0;
        else if (tick)    tick_cnt <= tick_cnt + 1'b1;
    end

    AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_a) |-> flag_a); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_a && !(wr_en && wr_addr == '0 && !wr_flag_bit) |=> flag_a); // R9

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= CW'(LIMIT)); // R4

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_a && !$past(busy_a) |-> $stable(result_a)); // R2

    AST_DIFF_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(diff) && $rose(busy_a) && !$past(busy_b) |-> busy_b); // R10
endmodule

bind dual_conv_sequencer convseq_checker #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CONV_CLKS (CONV_CLKS),
    .TRACK_CLKS(TRACK_CLKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_a     (busy_a),
    .busy_b     (busy_b),
    .flag_a     (flag_a_w),
    .diff       (diff_w),
    .tick       (conv_tick),
    .result_a   (res_a_w),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_flag_bit(wr_data[1])
);

// File: tb/dual_conv_sequencer_bench.sv
module dual_conv_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        tmr2_ovf = 1'b0, tmr3_ovf = 1'b0;
    logic        ext_start_a = 1'b0, ext_start_b = 1'b0;
    logic [15:0] ain_a = '0, ain_b = '0;
    logic        busy_a, busy_b, irq_a, irq_b;

    int n_chk = 0, n_fail = 0;
    bit reported = 0;

    always #10 clk = ~clk;

    dual_conv_sequencer u_dual_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf),
        .ext_start_a(ext_start_a), .ext_start_b(ext_start_b), .ain_a(ain_a), .ain_b(ain_b),
        .busy_a(busy_a), .busy_b(busy_b), .irq_a(irq_a), .irq_b(irq_b)
    );

    // {chan, mode[2:0], track, 3'b0, div[7:0], ain[15:0]}
    localparam logic [31:0] VEC [8] = '{
        {1'b0, 3'd0, 1'b0, 3'd0, 8'd0, 16'h1234},
        {1'b0, 3'd0, 1'b1, 3'd0, 8'd0, 16'hBEEF},
        {1'b0, 3'd1, 1'b0, 3'd0, 8'd3, 16'h0001},
        {1'b0, 3'd2, 1'b1, 3'd0, 8'd1, 16'h8000},
        {1'b0, 3'd3, 1'b1, 3'd0, 8'd0, 16'h7FFF},
        {1'b1, 3'd0, 1'b0, 3'd0, 8'd2, 16'hFFFF},
        {1'b1, 3'd3, 1'b0, 3'd0, 8'd0, 16'h0F0F},
        {1'b1, 3'd4, 1'b1, 3'd0, 8'd0, 16'h5A5A}
    };

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic logic [15:0] cfg(input int mode, input bit trk, input bit ie, input bit dif);
        return 16'((dif ? 64 : 0) | (mode << 4) | (ie ? 8 : 0) | (trk ? 4 : 0));
    endfunction

    task automatic measure(input bit ch, output int len);
        int w = 0;
        len = 0;
        while (((ch ? busy_b : busy_a) == 1'b0) && w < 12) begin
            @(negedge clk); w++;
        end
        while ((ch ? busy_b : busy_a) && len < 5000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int w = 0;
        while ((busy_a || busy_b) && w < 5000) begin
            @(negedge clk); w++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!busy_a && !busy_b && !irq_a && !irq_b, "R1 outputs after reset",
            {busy_a, busy_b, irq_a, irq_b}, 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk(v == 16'h0, "R1 register after reset", v, 0);
        end

        // Table-driven start modes
        for (int i = 0; i < 8; i++) begin
            logic [31:0] e;
            bit ch, trk;
            int mode, dv, n, maxl, minl;
            logic [15:0] ain;
            e = VEC[i];
            ch = e[31]; mode = int'(e[30:28]); trk = e[27]; dv = int'(e[23:16]); ain = e[15:0];
            wr(3'd2, 16'(dv));
            wr(3'd0, 16'h0);
            wr(3'd1, 16'h0);
            wr(ch ? 3'd1 : 3'd0, cfg(mode, trk, 1'b1, 1'b0));
            if (ch) ain_b = ain; else ain_a = ain;
            case (mode)
                0: wr(ch ? 3'd1 : 3'd0, cfg(0, trk, 1'b1, 1'b0) | 16'h1);
                1: begin @(negedge clk); tmr2_ovf = 1'b1; @(negedge clk); tmr2_ovf = 1'b0; end
                2: begin @(negedge clk); tmr3_ovf = 1'b1; @(negedge clk); tmr3_ovf = 1'b0; end
                3: begin @(negedge clk); if (ch) ext_start_b = 1'b1; else ext_start_a = 1'b1; end
                default: wr(3'd0, 16'h0001);
            endcase
            measure(ch, len);
            ext_start_a = 1'b0; ext_start_b = 1'b0;
            n = (trk && mode != 3) ? 34 : 16;
            maxl = n * (dv + 1);
            minl = maxl - dv;
            case (mode)
                0: chk(len >= minl && len <= maxl, "R2 R3 R4 software start busy length", len, maxl);
                1, 2: chk(len >= minl && len <= maxl, "R5 R3 R4 timer start busy length", len, maxl);
                3: chk(len >= minl && len <= maxl, "R6 pin start busy length", len, maxl);
                default: chk(len >= minl && len <= maxl, "R7 start from A write, B busy length", len, maxl);
            endcase
            wait_idle();
            repeat (4) @(negedge clk);
            rd(ch ? 3'd4 : 3'd3, v);
            chk(v == ain, "R2 result equals input word", v, ain);
            rd(ch ? 3'd1 : 3'd0, v);
            chk(v[1] == 1'b1 && (ch ? irq_b : irq_a) == 1'b1, "R9 flag and irq after completion",
                {v[1], ch ? irq_b : irq_a}, 2'b11);
            chk(int'(v[6:4]) == mode, "R11 mode field readback", v[6:4], mode);
        end

        // R5: wrong timer ignored
        wr(3'd2, 16'h0);
        wr(3'd0, cfg(1, 1'b0, 1'b0, 1'b0));
        @(negedge clk); tmr3_ovf = 1'b1; @(negedge clk); tmr3_ovf = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_a == 1'b0, "R5 other timer pulse ignored", busy_a, 0);

        // R8: start while busy ignored
        wr(3'd0, cfg(0, 1'b0, 1'b0, 1'b0));
        wr(3'd0, cfg(0, 1'b0, 1'b0, 1'b0) | 16'h1);
        len = 0;
        for (int k = 0; k < 40; k++) begin
            if (busy_a) len++;
            if (k == 4) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = cfg(0, 1'b0, 1'b0, 1'b0) | 16'h1; end
            else wr_en = 1'b0;
            @(negedge clk);
        end
        chk(len == 16, "R8 restart while busy ignored, length", len, 16);
        chk(busy_a == 1'b0, "R8 no queued second conversion", busy_a, 0);

        // R9: flag stickiness and irq gating
        rd(3'd0, v);
        chk(v[1] == 1'b1 && irq_a == 1'b0, "R9 flag set, irq masked", {v[1], irq_a}, 2'b10);
        wr(3'd0, cfg(0, 1'b0, 1'b0, 1'b0) | 16'h2);
        rd(3'd0, v);
        chk(v[1] == 1'b1, "R9 write 1 leaves flag", v[1], 1);
        wr(3'd0, cfg(0, 1'b0, 1'b1, 1'b0) | 16'h2);
        chk(irq_a == 1'b1, "R9 irq with enable", irq_a, 1);
        wr(3'd0, cfg(0, 1'b0, 1'b1, 1'b0));
        rd(3'd0, v);
        chk(v[1] == 1'b0 && irq_a == 1'b0, "R9 write 0 clears flag", {v[1], irq_a}, 0);

        // R6: exact pin latency
        wr(3'd0, cfg(3, 1'b0, 1'b0, 1'b0));
        @(negedge clk); ext_start_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(busy_a == 1'b0, "R6 busy low after two edges", busy_a, 0);
        @(negedge clk);
        chk(busy_a == 1'b1, "R6 busy high after third edge", busy_a, 1);
        wait_idle();
        ext_start_a = 1'b0;
        repeat (4) @(negedge clk);

        // R10: differential lockstep and sum
        wr(3'd1, cfg(1, 1'b0, 1'b0, 1'b0));
        wr(3'd0, cfg(0, 1'b0, 1'b0, 1'b1));
        ain_a = 16'hF000; ain_b = 16'h2000;
        wr(3'd0, cfg(0, 1'b0, 1'b0, 1'b1) | 16'h1);
        chk(busy_a && busy_b, "R10 both channels start together", {busy_a, busy_b}, 2'b11);
        measure(1'b1, len);
        chk(len == 16, "R10 B runs conversion length", len, 16);
        wait_idle();
        rd(3'd3, v);
        chk(v == 16'h1000, "R10 A holds wrapped sum", v, 16'h1000);
        rd(3'd4, v);
        chk(v == 16'h2000, "R10 B holds its own word", v, 16'h2000);
        @(negedge clk); tmr2_ovf = 1'b1; @(negedge clk); tmr2_ovf = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_b == 1'b0, "R10 B own source ignored", busy_b, 0);
        wr(3'd0, 16'h0);

        summary();
        $finish;
    end
endmodule